// File: doc/BRIEF.md
# DAC Termination Autodetect Controller

This block decides, once per video frame, which of three video DAC outputs stay powered. Its inputs are the latched results of two termination comparators (one on the composite DAC, one on the luma DAC), a frame-start strobe, a small mode field, one manual power-down bit per DAC and one enable bit per DAC. Its outputs are two termination status bits for software to read and three effective power-enable signals for the DACs.

In the report-only mode the block only records termination. Power then follows the enable and manual power-down bits alone. In the automatic mode, with all three DACs enabled, an unterminated composite or luma output is switched off. The chroma DAC is switched off whenever the luma DAC is off. Every input is sampled only on the frame-start strobe, so the outputs move only at frame boundaries.

Top module: `dac_term_detect`

## Requirements
- R1: After reset all three power outputs are 1 and both status bits read 1 (terminated).
- R2: On each frame-start strobe, in every mode, `termStatus[0]` takes the composite comparator and `termStatus[1]` takes the luma comparator (1 = terminated).
- R3: Between frame-start strobes, `termStatus` and `dacPowerOn` hold their values, whatever the other inputs do.
- R4: Mode code 2'b00 is report-only. On a strobe, `dacPowerOn[i]` = `dacEnable[i]` AND NOT `manualPd[i]`. Bit 0 is composite, bit 1 is luma and bit 2 is chroma.
- R5: Mode codes 2'b10 and 2'b11 are unused and behave exactly as code 2'b00.
- R6: In automatic mode (code 2'b01), with all enables set, the composite DAC is powered after a strobe only if its comparator read terminated and its manual power-down bit is clear.
- R7: In automatic mode, with all enables set, the luma DAC is powered after a strobe only if its comparator read terminated and its manual power-down bit is clear.
- R8: In automatic mode, with all enables set, the chroma DAC is off whenever the luma DAC is off, for either reason.
- R9: If any enable bit is clear, the automatic mode has no effect and power follows the R4 rule.
- R10: A set manual power-down bit always turns its DAC off, even when automatic detection would keep it on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameStart | input | 1 | One-cycle strobe that marks the start of a frame |
| compTermIn | input | 1 | Composite comparator result, 1 = terminated |
| lumaTermIn | input | 1 | Luma comparator result, 1 = terminated |
| modeSel | input | MODE_W | Autodetect mode selection |
| manualPd | input | 3 | Manual power-down per DAC (0 composite, 1 luma, 2 chroma) |
| dacEnable | input | 3 | Enable per DAC (same bit order) |
| termStatus | output | 2 | Termination status (0 composite, 1 luma) |
| dacPowerOn | output | 3 | Effective power enable per DAC |

## Verification
The bench builds the block with the default values, MODE_W = 2 and AUTO_MODE = 1. With these values all four mode codes can be reached, so both unused codes are driven and compared against report-only behaviour. The bench sweeps comparator, enable and manual power-down combinations in automatic mode. Among them are the cases where a manual power-down of the luma DAC must also pull the chroma DAC off, and where one clear enable must disable the automatic decision. Between strobes it changes every input and confirms that the outputs hold.

// File: rtl/dac_term_pkg.sv
package dac_term_pkg;
  localparam int DAC_COUNT  = 3;
  localparam int COMP_IDX   = 0;
  localparam int LUMA_IDX   = 1;
  localparam int CHROMA_IDX = 2;
  localparam int SENSE_COUNT = 2;

  typedef struct packed {
    logic sample;      // capture inputs this cycle
    logic autoActive;  // automatic power decision applies
  } ctrl_strobe_t;
endpackage

// File: rtl/dac_term_ctrl.sv
module dac_term_ctrl
  import dac_term_pkg::*;
#(
  parameter int MODE_W    = 2,
  parameter int AUTO_MODE = 1
) (
  input  logic                 frameStart,
  input  logic [MODE_W-1:0]    modeSel,
  input  logic [DAC_COUNT-1:0] dacEnable,
  output ctrl_strobe_t         strobes
);
  localparam logic [MODE_W-1:0] AutoCode = MODE_W'(AUTO_MODE);

  logic modeIsAuto;
  logic allEnabled;

  always_comb begin
    // every other code, the unused ones included, means report-only
    modeIsAuto = (modeSel == AutoCode);
    allEnabled = &dacEnable;
    strobes.sample     = frameStart;
    strobes.autoActive = modeIsAuto && allEnabled;
  end
endmodule

// File: rtl/dac_term_dp.sv
module dac_term_dp
  import dac_term_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrl_strobe_t           strobes,
  input  logic                   compTermIn,
  input  logic                   lumaTermIn,
  input  logic [DAC_COUNT-1:0]   manualPd,
  input  logic [DAC_COUNT-1:0]   dacEnable,
  output logic [SENSE_COUNT-1:0] termStatus,
  output logic [DAC_COUNT-1:0]   dacPowerOn
);
  logic [SENSE_COUNT-1:0] senseNow;
  logic [DAC_COUNT-1:0]   basePower;
  logic [DAC_COUNT-1:0]   nextPower;
  logic                   autoActiveQ;

  assign senseNow[COMP_IDX] = compTermIn;
  assign senseNow[LUMA_IDX] = lumaTermIn;

  genvar gi;
  generate
    for (gi = 0; gi < DAC_COUNT; gi++) begin : g_base
      assign basePower[gi] = dacEnable[gi] & ~manualPd[gi];
    end
  endgenerate

  always_comb begin
    nextPower = basePower;
    if (strobes.autoActive) begin
      nextPower[COMP_IDX]   = basePower[COMP_IDX] & senseNow[COMP_IDX];
      nextPower[LUMA_IDX]   = basePower[LUMA_IDX] & senseNow[LUMA_IDX];
      nextPower[CHROMA_IDX] = basePower[CHROMA_IDX] & nextPower[LUMA_IDX];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      termStatus  <= '1;
      dacPowerOn  <= '1;
      autoActiveQ <= 1'b0;
    end else if (strobes.sample) begin
      termStatus  <= senseNow;
      dacPowerOn  <= nextPower;
      autoActiveQ <= strobes.autoActive;
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.sample |=> $stable(termStatus) && $stable(dacPowerOn));

  assert_status_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sample |=> termStatus == $past({lumaTermIn, compTermIn}));

  assert_report_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sample && !strobes.autoActive |=> dacPowerOn == $past(dacEnable & ~manualPd));

  assert_comp_auto_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sample && strobes.autoActive && !compTermIn |=> !dacPowerOn[COMP_IDX]);

  assert_luma_auto_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sample && strobes.autoActive && !lumaTermIn |=> !dacPowerOn[LUMA_IDX]);

  assert_chroma_tie_R8: assert property (@(posedge clk) disable iff (!rstN)
    autoActiveQ && !dacPowerOn[LUMA_IDX] |-> !dacPowerOn[CHROMA_IDX]);

  assert_manual_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sample |=> (dacPowerOn & $past(manualPd)) == '0);
endmodule

// File: rtl/dac_term_detect.sv
module dac_term_detect
  import dac_term_pkg::*;
#(
  parameter int MODE_W    = 2,
  parameter int AUTO_MODE = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        compTermIn,
  input  logic        lumaTermIn,
  input  logic [MODE_W-1:0] modeSel,
  input  logic [2:0]  manualPd,
  input  logic [2:0]  dacEnable,
  output logic [1:0]  termStatus,
  output logic [2:0]  dacPowerOn
);
  ctrl_strobe_t strobes;

  dac_term_ctrl #(.MODE_W(MODE_W), .AUTO_MODE(AUTO_MODE)) u_ctrl (
    .frameStart (frameStart),
    .modeSel    (modeSel),
    .dacEnable  (dacEnable),
    .strobes    (strobes)
  );

  dac_term_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .compTermIn (compTermIn),
    .lumaTermIn (lumaTermIn),
    .manualPd   (manualPd),
    .dacEnable  (dacEnable),
    .termStatus (termStatus),
    .dacPowerOn (dacPowerOn)
  );

  assert_reset_R1: assert property (@(posedge clk)
    !rstN |=> (termStatus == 2'b11) && (dacPowerOn == 3'b111));
endmodule

// File: tb/dac_term_detect_tb.sv
module dac_term_detect_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStart = 1'b0;
  logic       compTermIn = 1'b1;
  logic       lumaTermIn = 1'b1;
  logic [1:0] modeSel = 2'b00;
  logic [2:0] manualPd = 3'b000;
  logic [2:0] dacEnable = 3'b111;
  logic [1:0] termStatus;
  logic [2:0] dacPowerOn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [4:0] value;   // {power[2:0], status[1:0]}
    string      tag;
  } exp_t;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_term_detect u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .compTermIn(compTermIn), .lumaTermIn(lumaTermIn),
    .modeSel(modeSel), .manualPd(manualPd), .dacEnable(dacEnable),
    .termStatus(termStatus), .dacPowerOn(dacPowerOn)
  );

  function automatic logic [4:0] model(input logic [1:0] m, input logic [2:0] en,
                                       input logic [2:0] pd, input logic c, input logic l);
    logic autoOn;
    logic [2:0] p;
    autoOn = (m == 2'b01) && (en == 3'b111);
    p[0] = en[0] & ~pd[0] & ~(autoOn & ~c);
    p[1] = en[1] & ~pd[1] & ~(autoOn & ~l);
    p[2] = en[2] & ~pd[2] & ~(autoOn & ~p[1]);
    return {p, l, c};
  endfunction

  task automatic compare(input logic [4:0] act, input logic [4:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: set inputs, push expected item, pulse the strobe for one cycle
  task automatic frame(input logic [1:0] m, input logic [2:0] en, input logic [2:0] pd,
                       input logic c, input logic l, input string tag);
    exp_t e;
    @(negedge clk);
    modeSel = m; dacEnable = en; manualPd = pd; compTermIn = c; lumaTermIn = l;
    e.value = model(m, en, pd, c, l);
    e.tag = tag;
    expQ.push_back(e);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // monitor: after each strobe edge, pop and compare
  initial begin
    forever begin
      @(posedge clk);
      if (frameStart) begin
        #1;
        if (expQ.size() == 0) begin
          compare(5'b0, 5'b1, "R2 queue underflow");
        end else begin
          exp_t e;
          e = expQ.pop_front();
          compare({dacPowerOn, termStatus}, e.value, e.tag);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] held;
    repeat (3) @(negedge clk);
    compare({dacPowerOn, termStatus}, 5'b11111, "R1 reset state");
    rstN = 1'b1;
    @(negedge clk);
    compare({dacPowerOn, termStatus}, 5'b11111, "R1 after release");

    frame(2'b00, 3'b111, 3'b000, 1'b0, 1'b0, "R2 R4 mode0 unterminated keeps power");
    frame(2'b00, 3'b101, 3'b010, 1'b1, 1'b0, "R4 mode0 enables and pd");
    frame(2'b10, 3'b111, 3'b001, 1'b0, 1'b1, "R5 code2 as mode0");
    frame(2'b11, 3'b111, 3'b000, 1'b0, 1'b0, "R5 code3 as mode0");
    frame(2'b01, 3'b111, 3'b000, 1'b1, 1'b1, "R6 R7 auto all terminated");
    frame(2'b01, 3'b111, 3'b000, 1'b0, 1'b1, "R6 auto composite open");
    frame(2'b01, 3'b111, 3'b000, 1'b1, 1'b0, "R7 R8 auto luma open drops chroma");
    frame(2'b01, 3'b111, 3'b010, 1'b1, 1'b1, "R8 R10 manual luma off drops chroma");
    frame(2'b01, 3'b111, 3'b101, 1'b1, 1'b1, "R10 manual beats auto power-up");
    frame(2'b01, 3'b011, 3'b000, 1'b0, 1'b0, "R9 chroma enable clear disables auto");
    frame(2'b01, 3'b110, 3'b000, 1'b0, 1'b0, "R9 composite enable clear disables auto");
    frame(2'b01, 3'b111, 3'b000, 1'b0, 1'b0, "R2 R8 auto both open");

    // R3: change everything without a strobe, outputs must hold
    held = {dacPowerOn, termStatus};
    @(negedge clk);
    modeSel = 2'b00; dacEnable = 3'b111; manualPd = 3'b000;
    compTermIn = 1'b1; lumaTermIn = 1'b1;
    repeat (4) @(negedge clk);
    compare({dacPowerOn, termStatus}, held, "R3 hold between strobes");
    modeSel = 2'b01; manualPd = 3'b111;
    repeat (3) @(negedge clk);
    compare({dacPowerOn, termStatus}, held, "R3 hold after second change");

    frame(2'b00, 3'b111, 3'b000, 1'b1, 1'b1, "R4 recovery all on");
    repeat (2) @(negedge clk);
    compare({27'b0, expQ.size()} == 0 ? 5'b0 : 5'b1, 5'b0, "R2 all strobes observed");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule